// File: doc/BRIEF.md
# Secured Sector Protection Check Sequencer

This block runs, on the host side, the check that tells whether the one-time secured sector of a parallel flash has been locked. A single start pulse launches a fixed script. The block selects the elevated level on the flash reset pin and lets the required settling time pass. It issues an entry write and a verify write, then reads the status byte from a secured-sector address. It drops the elevated level and sends a reset command. At the end it reports a verdict.

The flash is reached through a plain synchronous bus master port: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and a read-valid input with its data. The read may take any number of cycles to return. The analog generation of the high reset voltage is outside the block. It is represented by a select output that is high while the elevated level must be applied. The verdict is "protected", "unprotected" (both flags low) or "unexpected data" (error flag).

Top module: `sec_prot_chk`

## Requirements
- R1: After reset, busy_o, done_o, hv_sel_o, bus_we_o, bus_re_o, prot_o and err_o are all low.
- R2: A start_i pulse seen while busy_o is low raises busy_o and hv_sel_o in the next cycle. hv_sel_o stays high until the read data has been accepted.
- R3: No bus strobe is issued during the first WAIT_CYC cycles in which hv_sel_o is high. WAIT_CYC = ceil(CLK_HZ * WAIT_NS / 1e9), at least 1.
- R4: The first bus operation is a write of 60h to UNLOCK_ADDR.
- R5: The second operation is a write of 40h to SEC_ADDR, where SEC_ADDR has bit 6 = 0, bit 1 = 1 and bit 0 = 0. The third operation is a one-cycle read strobe at SEC_ADDR. The block then waits any number of cycles for bus_rvalid_i.
- R6: Once the read data is accepted, hv_sel_o falls. The fourth and last operation is a write of F0h to UNLOCK_ADDR, issued with hv_sel_o low.
- R7: done_o is a one-cycle pulse in the cycle after the F0h write. busy_o is high in that cycle and low in the next.
- R8: A read value of 01h sets prot_o = 1 and err_o = 0. A value of 00h gives prot_o = 0 and err_o = 0. Any other value gives err_o = 1 and prot_o = 0. The flags appear with done_o, are held, and are cleared when the next start is accepted.
- R9: start_i while busy_o is high has no effect on the sequence. bus_rvalid_i outside the read wait has no effect on the flags.
- R10: bus_we_o and bus_re_o are never high together, and neither is high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_we_o | output | 1 | One-cycle write strobe |
| bus_re_o | output | 1 | One-cycle read strobe |
| bus_rvalid_i | input | 1 | Read data valid |
| bus_rdata_i | input | DW | Read data |
| hv_sel_o | output | 1 | Selects the elevated level on the flash reset pin |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prot_o | output | 1 | Sector reported protected |
| err_o | output | 1 | Unexpected status byte |

## Verification
The bench counts the cycles between the rise of the level select and the first strobe. A design that shortened the settling wait, or that let the entry write slip into it, would issue commands too early. It varies read latency, so a design that captured data on the strobe cycle or timed out would latch the wrong byte. It feeds 01h, 00h and two odd values, which catches a decoder that treats any nonzero byte as "protected". It also checks that the reset command goes out only after the select has dropped, and that stray start pulses and read-valids change neither the bus script nor the held verdict.

// File: rtl/spv_pkg.sv
package spv_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WAIT,
      S_WR_ENTER,
      S_WR_VERIFY,
      S_RD,
      S_RD_WAIT,
      S_HV_OFF,
      S_WR_RESET,
      S_DONE
   } spv_state_e;

   localparam logic [7:0] CMD_ENTER  = 8'h60;
   localparam logic [7:0] CMD_VERIFY = 8'h40;
   localparam logic [7:0] CMD_RESET  = 8'hF0;
   localparam logic [7:0] STAT_LOCK  = 8'h01;
   localparam logic [7:0] STAT_OPEN  = 8'h00;

endpackage

// File: rtl/spv_delay.sv
module spv_delay #(
   parameter int CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int CW = $clog2(CYC + 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("spv_delay: CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/spv_verdict.sv
module spv_verdict #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] data_i,
   output logic          prot_o,
   output logic          err_o
);
   logic is_lock, is_open;

   assign is_lock = (data_i == DW'(spv_pkg::STAT_LOCK));
   assign is_open = (data_i == DW'(spv_pkg::STAT_OPEN));
   assign prot_o  = is_lock;
   assign err_o   = !is_lock && !is_open;
endmodule

// File: rtl/sec_prot_chk.sv
module sec_prot_chk #(
   parameter int          CLK_HZ       = 100_000_000,
   parameter int          WAIT_NS      = 1000,
   parameter int          AW           = 21,
   parameter int          DW           = 8,
   parameter logic [20:0] UNLOCK_ADDR  = 21'h000555,
   parameter logic [20:0] SEC_ADDR     = 21'h1F0082,
   parameter bit          USE_ID_LEVEL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic          bus_we_o,
   output logic          bus_re_o,
   input  logic          bus_rvalid_i,
   input  logic [DW-1:0] bus_rdata_i,
   output logic          hv_sel_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          prot_o,
   output logic          err_o
);
   import spv_pkg::*;

   localparam longint unsigned PROD    = longint'(CLK_HZ) * longint'(WAIT_NS);
   localparam int              RAW_CYC = int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);
   localparam int              WAIT_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

   if (AW < 7 || AW > 21) begin : g_bad_aw
      $error("sec_prot_chk: AW must lie in 7..21");
   end
   if (DW < 8) begin : g_bad_dw
      $error("sec_prot_chk: DW must be at least 8");
   end
   if (SEC_ADDR[6] != 1'b0 || SEC_ADDR[1] != 1'b1 || SEC_ADDR[0] != 1'b0) begin : g_bad_sec
      $error("sec_prot_chk: SEC_ADDR needs bit6=0, bit1=1, bit0=0");
   end

   spv_state_e    state_q, state_d;
   logic [DW-1:0] rd_q;
   logic          prot_q, err_q;
   logic          wait_done, v_prot, v_err, hv_phase, accept;

   spv_delay #(.CYC(WAIT_CYC)) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (state_q == S_WAIT),
      .expired_o (wait_done)
   );

   spv_verdict #(.DW(DW)) u_verdict (
      .data_i (rd_q),
      .prot_o (v_prot),
      .err_o  (v_err)
   );

   assign accept = (state_q == S_RD_WAIT) && bus_rvalid_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:      if (start_i)   state_d = S_WAIT;
         S_WAIT:      if (wait_done) state_d = S_WR_ENTER;
         S_WR_ENTER:  state_d = S_WR_VERIFY;
         S_WR_VERIFY: state_d = S_RD;
         S_RD:        state_d = S_RD_WAIT;
         S_RD_WAIT:   if (bus_rvalid_i) state_d = S_HV_OFF;
         S_HV_OFF:    state_d = S_WR_RESET;
         S_WR_RESET:  state_d = S_DONE;
         S_DONE:      state_d = S_IDLE;
         default:     state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         rd_q    <= '0;
         prot_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) rd_q <= bus_rdata_i;
         if (state_q == S_IDLE && start_i) begin
            prot_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (state_q == S_WR_RESET) begin
            prot_q <= v_prot;
            err_q  <= v_err;
         end
      end
   end

   always_comb begin
      bus_we_o    = 1'b0;
      bus_re_o    = 1'b0;
      bus_addr_o  = '0;
      bus_wdata_o = '0;
      unique case (state_q)
         S_WR_ENTER: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = UNLOCK_ADDR[AW-1:0];
            bus_wdata_o = DW'(CMD_ENTER);
         end
         S_WR_VERIFY: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = SEC_ADDR[AW-1:0];
            bus_wdata_o = DW'(CMD_VERIFY);
         end
         S_RD, S_RD_WAIT: begin
            bus_re_o    = (state_q == S_RD);
            bus_addr_o  = SEC_ADDR[AW-1:0];
         end
         S_WR_RESET: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = UNLOCK_ADDR[AW-1:0];
            bus_wdata_o = DW'(CMD_RESET);
         end
         default: ;
      endcase
   end

   assign hv_phase = (state_q == S_WAIT) || (state_q == S_WR_ENTER) ||
                     (state_q == S_WR_VERIFY) || (state_q == S_RD) ||
                     (state_q == S_RD_WAIT);

   if (USE_ID_LEVEL) begin : g_id_level
      assign hv_sel_o = hv_phase;
   end else begin : g_logic_high
      assign hv_sel_o = 1'b0;
   end

   assign busy_o = (state_q != S_IDLE);
   assign done_o = (state_q == S_DONE);
   assign prot_o = prot_q;
   assign err_o  = err_q;
endmodule

// File: rtl/spv_chk.sv
module spv_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          bus_we_o,
   input logic          bus_re_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          hv_sel_o,
   input logic          busy_o,
   input logic          done_o,
   input logic          prot_o,
   input logic          err_o
);
   import spv_pkg::*;

   p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we_o && bus_re_o));

   p_bus_in_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_o || bus_re_o) |-> busy_o);

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   p_hv_in_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hv_sel_o |-> busy_o);

   p_reset_cmd_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_o && bus_wdata_o == DW'(CMD_RESET)) |-> !hv_sel_o);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(prot_o && err_o));

   p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!prot_o && !err_o));

   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(prot_o) && $stable(err_o)));
endmodule

bind sec_prot_chk spv_chk #(.DW(DW)) u_spv_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .bus_we_o    (bus_we_o),
   .bus_re_o    (bus_re_o),
   .bus_wdata_o (bus_wdata_o),
   .hv_sel_o    (hv_sel_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .prot_o      (prot_o),
   .err_o       (err_o)
);

// File: tb/sec_prot_chk_tb_top.sv
module sec_prot_chk_tb_top;
   localparam int          AW     = 21;
   localparam int          DW     = 8;
   localparam logic [20:0] UNLOCK = 21'h000555;
   localparam logic [20:0] SECA   = 21'h1F0082;
   localparam int          EXP_WAIT = (100_000_000 / 1_000_000) * 1000 / 1000; // 100 MHz, 1000 ns

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rvalid = 1'b0;
   logic [DW-1:0] rdata = 8'h5A;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic we, re, hv, busy, done, prot, err;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #5 clk = ~clk;

   sec_prot_chk #(.CLK_HZ(100_000_000), .WAIT_NS(1000), .AW(AW), .DW(DW),
                  .UNLOCK_ADDR(UNLOCK), .SEC_ADDR(SECA), .USE_ID_LEVEL(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we), .bus_re_o(re),
      .bus_rvalid_i(rvalid), .bus_rdata_i(rdata),
      .hv_sel_o(hv), .busy_o(busy), .done_o(done), .prot_o(prot), .err_o(err));

   // bus operation log, filled at falling edges
   logic          ev_wr [0:15];
   logic [AW-1:0] ev_ad [0:15];
   logic [DW-1:0] ev_dt [0:15];
   logic          ev_hv [0:15];
   int ev_n = 0, hv_wait = 0;
   bit seen_we = 0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if ((we || re) && ev_n < 16) begin
         ev_wr[ev_n] = we; ev_ad[ev_n] = addr; ev_dt[ev_n] = wdata; ev_hv[ev_n] = hv;
         ev_n = ev_n + 1;
      end
      if (hv && !we && !re && !seen_we) hv_wait = hv_wait + 1;
      if (we) seen_we = 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic respond(input logic [DW-1:0] val, input int lat);
      @(negedge clk);
      while (!re) @(negedge clk);
      repeat (lat) @(negedge clk);
      rvalid = 1'b1; rdata = val;
      @(negedge clk);
      rvalid = 1'b0; rdata = 8'h5A;
   endtask

   task automatic drive_seq(input bit extra_start);
      int guard = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && hv, "R2 busy/hv after start", {busy, hv}, 2'b11);
      chk(!prot && !err, "R8 flags cleared on start", {prot, err}, 0);
      if (extra_start) begin
         repeat (10) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && guard < 2000) begin @(negedge clk); guard++; end
   endtask

   task automatic run_case(input logic [DW-1:0] val, input int lat,
                           input bit ep, input bit ee, input bit extra_start);
      ev_n = 0; hv_wait = 0; seen_we = 0;
      fork
         drive_seq(extra_start);
         respond(val, lat);
      join
      chk(done && busy, "R7 done pulse with busy", {done, busy}, 2'b11);
      chk(prot == ep && err == ee, "R8 verdict", {prot, err}, {ep, ee});
      chk(hv_wait == EXP_WAIT, "R3 settle cycles", hv_wait, EXP_WAIT);
      chk(ev_n == 4, "R9 operation count", ev_n, 4);
      chk(ev_wr[0] && ev_ad[0] == UNLOCK && ev_dt[0] == 8'h60 && ev_hv[0],
          "R4 entry write", {ev_ad[0], ev_dt[0]}, {UNLOCK, 8'h60});
      chk(ev_wr[1] && ev_ad[1] == SECA && ev_dt[1] == 8'h40 && ev_hv[1],
          "R5 verify write", {ev_ad[1], ev_dt[1]}, {SECA, 8'h40});
      chk(!ev_wr[2] && ev_ad[2] == SECA && ev_hv[2], "R5 status read", ev_ad[2], SECA);
      chk(ev_wr[3] && ev_ad[3] == UNLOCK && ev_dt[3] == 8'hF0 && !ev_hv[3],
          "R6 reset write, select low", {ev_hv[3], ev_dt[3]}, {1'b0, 8'hF0});
      @(negedge clk);
      chk(!done && !busy, "R7 done one cycle", {done, busy}, 0);
      repeat (3) @(negedge clk);
      chk(prot == ep && err == ee, "R8 verdict held", {prot, err}, {ep, ee});
   endtask

   task automatic t_reset();
      chk(!busy && !done && !hv && !we && !re && !prot && !err, "R1 reset state",
          {busy, done, hv, we, re, prot, err}, 0);
   endtask

   task automatic t_stray_rvalid();
      @(negedge clk);
      rvalid = 1'b1; rdata = 8'h01;
      @(negedge clk);
      rvalid = 1'b0; rdata = 8'h5A;
      repeat (2) @(negedge clk);
      chk(err && !prot && !busy, "R9 stray rvalid ignored", {prot, err, busy}, 3'b010);
   endtask

   task automatic t_idle_bus();
      int bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (we || re || hv) bad++;
      end
      chk(bad == 0, "R10 bus quiet while idle", bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      run_case(8'h01, 1, 1'b1, 1'b0, 1'b0);   // protected, fast read
      run_case(8'h00, 6, 1'b0, 1'b0, 1'b0);   // unprotected, slow read
      run_case(8'hA5, 2, 1'b0, 1'b1, 1'b1);   // odd byte, stray start
      t_stray_rvalid();
      run_case(8'h02, 3, 1'b0, 1'b1, 1'b0);   // odd byte near 01h
      run_case(8'h01, 12, 1'b1, 1'b0, 1'b0);
      t_idle_bus();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule